// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt request lines, latches their rising edges, and tells a processor which one to service. It arbitrates with a fixed ordering in which input 0 wins. An input already in service holds off every request of equal or lower rank. The processor reaches the block through a byte-wide register port with two addresses, which `bus_a0` chooses. The even address takes commands and the odd address takes the mask and the init words.

After an initialization sequence the block raises `int_req` for the best eligible request. The processor answers in one of two ways. It can pulse `int_ack`, which drives an 8-bit vector made of a programmable base plus the input number. Or it can issue a poll command, so that the next even-address read acts as the acknowledge.

Software closes an interrupt with a non-specific end-of-interrupt command. Software can read back the request or the in-service register. A request that disappears before it is acknowledged is reported as the lowest-ranked input, with no in-service bit set.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at the odd address, `int_req` is 0, and an even-address read returns the request register, which is 0.
- R2: An even-address write with data bit 4 set starts initialization. The following odd-address writes are the vector base, then the cascade word, then (if bit 0 was set) the mode word, and none of them changes the mask. Odd-address writes after the sequence load the mask, and odd reads return it.
- R3: If the first init word has bit 1 set (single unit), the cascade word is skipped, so the sequence is base then mode.
- R4: An `int_ack` pulse drives `int_vector` = base with bits 2:0 cleared, OR the winning input number. In the same cycle the in-service bit of that input is set and its request bit is cleared.
- R5: A mask bit of 1 stops its input from raising `int_req`. A rising edge on a masked input is still latched in the request register, and it raises `int_req` once the input is unmasked.
- R6: Among several pending unmasked requests, the lowest-numbered input wins.
- R7: A pending request raises `int_req` only if no in-service bit is set at its own number or any lower number. A lower-numbered request still raises it while a higher-numbered input is in service.
- R8: Writing 0x20 to the even address clears only the lowest-numbered set in-service bit.
- R9: Writing 0x0C to the even address arms a poll. The next even read returns {valid, 0000, input number} in bits 7, 6:3 and 2:0, with the same in-service and request updates as R4. With nothing eligible it returns 0x07.
- R10: Writing 0x0B selects in-service readback and 0x0A selects request readback for even reads. The choice persists across reads and other commands, and the first init word restores request readback.
- R11: If a request disappears before acknowledge, the acknowledge reports input 7 (vector base+7) and sets no in-service bit, so in-service bit 7 reads 0.
- R12: The first init word clears the in-service and request registers and keeps the mask.
- R13: A rising edge that arrives in the same cycle as an acknowledge does not alter that acknowledge's vector. It is latched and raises `int_req` right after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_a0 | input | 1 | Register port address: 0 even, 1 odd |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq_lines | input | 8 | Interrupt request inputs, rising-edge sensitive |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge strobe, one cycle |
| int_vector | output | 8 | Vector, valid while `int_ack` is high |

## Verification
The clash that matters is an acknowledge that falls in the same clock cycle as a new rising edge on a higher-ranked input. The bench makes it happen by pulsing `int_ack` and raising the new line at the same falling edge. It judges the outcome in two places. The vector sampled during the pulse must name the request latched earlier, and `int_req` must rise right after for the new input. The in-service blocking logic is judged the same way over every ordered pair of inputs.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [1:0] {
      ST_READY = 2'd0,
      ST_BASE  = 2'd1,
      ST_CASC  = 2'd2,
      ST_MODE  = 2'd3
   } init_st_e;

   localparam logic [2:0] EOI_NS_CODE = 3'b001;

endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
   parameter int N_IN  = 8,
   parameter int IDX_W = $clog2(N_IN)
) (
   input  logic [N_IN-1:0]  vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   logic [N_IN:0]   seen;
   logic [N_IN-1:0] first;

   assign seen[0] = 1'b0;

   genvar g;
   generate
      for (g = 0; g < N_IN; g++) begin : g_chain
         assign first[g]  = vec[g] & ~seen[g];
         assign seen[g+1] = seen[g] | vec[g];
      end
   endgenerate

   assign any = seen[N_IN];

   always_comb begin
      idx = '0;
      for (int k = 0; k < N_IN; k++) begin
         if (first[k]) idx = IDX_W'(k);
      end
   end
endmodule

// File: rtl/pic_cfg_seq.sv
module pic_cfg_seq
   import pic_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(N_IN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a0,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   output logic              ready,
   output logic [DATA_W-1:0] vec_base,
   output logic [N_IN-1:0]   imr,
   output logic              sel_isr,
   output logic              poll_armed,
   output logic              eoi_pulse,
   output logic              init_pulse
);
   localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'((1 << IDX_W) - 1);

   init_st_e st_q;
   logic     need_mode_q, single_q;
   logic     odd_wr, cmd_wr, ocw3;

   assign odd_wr     = wr & a0;
   assign cmd_wr     = wr & ~a0;
   assign ready      = (st_q == ST_READY);
   assign init_pulse = cmd_wr & wdata[4];
   assign eoi_pulse  = cmd_wr & ready & ~wdata[4] & ~wdata[3]
                       & (wdata[7:5] == EOI_NS_CODE);
   assign ocw3       = cmd_wr & ready & ~wdata[4] & wdata[3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_READY;
         need_mode_q <= 1'b0;
         single_q    <= 1'b0;
         vec_base    <= '0;
      end else if (init_pulse) begin
         st_q        <= ST_BASE;
         need_mode_q <= wdata[0];
         single_q    <= wdata[1];
      end else if (odd_wr) begin
         unique case (st_q)
            ST_BASE: begin
               vec_base <= wdata & BASE_MASK;
               if (!single_q)        st_q <= ST_CASC;
               else if (need_mode_q) st_q <= ST_MODE;
               else                  st_q <= ST_READY;
            end
            ST_CASC:  st_q <= need_mode_q ? ST_MODE : ST_READY;
            ST_MODE:  st_q <= ST_READY;
            default:  st_q <= ST_READY;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                imr <= '1;
      else if (odd_wr && ready)  imr <= wdata[N_IN-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_isr    <= 1'b0;
         poll_armed <= 1'b0;
      end else if (init_pulse) begin
         sel_isr    <= 1'b0;
         poll_armed <= 1'b0;
      end else begin
         if (ocw3 && wdata[1]) sel_isr <= wdata[0];
         if (ocw3 && wdata[2])  poll_armed <= 1'b1;
         else if (rd && !a0)    poll_armed <= 1'b0;
      end
   end

   // R2: init words never reach the mask
   a_r2_init_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (odd_wr && !ready) |=> $stable(imr));

   // R10: readback selection survives reads
   a_r10_sel_persists: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr) |=> $stable(sel_isr));
endmodule

// File: rtl/pic_req_isr.sv
module pic_req_isr #(
   parameter int N_IN        = 8,
   parameter int SYNC_STAGES = 0,
   parameter int IDX_W       = $clog2(N_IN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IN-1:0]  lvl_in,
   input  logic             take_v,
   input  logic [IDX_W-1:0] take_idx,
   input  logic             eoi,
   input  logic             clr,
   output logic [N_IN-1:0]  irr,
   output logic [N_IN-1:0]  isr
);
   logic [N_IN-1:0] lvl, prev_q, rise, take_oh, eoi_oh;
   logic            isr_any;
   logic [IDX_W-1:0] isr_idx;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = lvl_in;
      end else begin : g_sync
         logic [N_IN-1:0] stg [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= lvl_in;
               for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign lvl = stg[SYNC_STAGES-1];
      end
   endgenerate

   pic_prio_find #(.N_IN(N_IN), .IDX_W(IDX_W)) u_isr_low (
      .vec (isr),
      .any (isr_any),
      .idx (isr_idx)
   );

   assign rise    = lvl & ~prev_q;
   assign take_oh = take_v ? (N_IN'(1) << take_idx) : '0;
   assign eoi_oh  = (eoi && isr_any) ? (N_IN'(1) << isr_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         irr    <= '0;
         isr    <= '0;
      end else begin
         prev_q <= lvl;
         if (clr) begin
            irr <= '0;
            isr <= '0;
         end else begin
            irr <= (irr | rise) & lvl & ~take_oh;
            isr <= (isr & ~eoi_oh) | take_oh;
         end
      end
   end

   // R4: an accepted acknowledge clears the request bit it served
   a_r4_take_clears_irr: assert property (@(posedge clk) disable iff (!rst_n)
      (take_v && !clr) |=> ((irr & $past(take_oh)) == '0));

   // R8: a lone end-of-interrupt retires exactly one in-service bit
   a_r8_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !take_v && !clr && (isr != '0))
      |=> ($countones(isr) + 1 == $past($countones(isr))));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_IN        = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_a0,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_IN-1:0]   irq_lines,
   output logic              int_req,
   input  logic              int_ack,
   output logic [DATA_W-1:0] int_vector
);
   localparam int IDX_W = $clog2(N_IN);
   localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(N_IN - 1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("prio_irq_ctrl: command codes need an 8-bit data path");
      end
      if (N_IN != 2 && N_IN != 4 && N_IN != 8) begin : g_bad_inputs
         $error("prio_irq_ctrl: N_IN must be 2, 4 or 8");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("prio_irq_ctrl: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              ready, sel_isr, poll_armed, eoi_pulse, init_pulse;
   logic [DATA_W-1:0] vec_base;
   logic [N_IN-1:0]   imr, irr, isr, pend;
   logic              pend_any, isr_any, blocked, valid, poll_rd, take_v;
   logic [IDX_W-1:0]  pend_idx, isr_idx, rsp_idx;
   logic [DATA_W-1:0] rsp_word, poll_word, imr_rd, irr_rd, isr_rd;

   pic_cfg_seq #(.N_IN(N_IN), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .a0         (bus_a0),
      .wr         (bus_wr),
      .rd         (bus_rd),
      .wdata      (bus_wdata),
      .ready      (ready),
      .vec_base   (vec_base),
      .imr        (imr),
      .sel_isr    (sel_isr),
      .poll_armed (poll_armed),
      .eoi_pulse  (eoi_pulse),
      .init_pulse (init_pulse)
   );

   pic_req_isr #(.N_IN(N_IN), .SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_in   (irq_lines),
      .take_v   (take_v),
      .take_idx (pend_idx),
      .eoi      (eoi_pulse),
      .clr      (init_pulse),
      .irr      (irr),
      .isr      (isr)
   );

   assign pend = irr & ~imr;

   pic_prio_find #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pend_pick (
      .vec (pend),
      .any (pend_any),
      .idx (pend_idx)
   );

   pic_prio_find #(.N_IN(N_IN), .IDX_W(IDX_W)) u_svc_pick (
      .vec (isr),
      .any (isr_any),
      .idx (isr_idx)
   );

   assign blocked = isr_any && (isr_idx <= pend_idx);
   assign valid   = ready && pend_any && !blocked;
   assign int_req = valid;
   assign poll_rd = bus_rd && !bus_a0 && poll_armed;
   assign take_v  = (int_ack || poll_rd) && valid;
   assign rsp_idx = valid ? pend_idx : SPUR_IDX;

   always_comb begin
      rsp_word = '0;
      rsp_word[IDX_W-1:0] = rsp_idx;
      poll_word = rsp_word;
      poll_word[DATA_W-1] = valid;
      imr_rd = '1;
      imr_rd[N_IN-1:0] = imr;
      irr_rd = '0;
      irr_rd[N_IN-1:0] = irr;
      isr_rd = '0;
      isr_rd[N_IN-1:0] = isr;
   end

   assign int_vector = int_ack ? (vec_base | rsp_word) : '0;

   always_comb begin
      if (!bus_rd)        bus_rdata = '0;
      else if (bus_a0)    bus_rdata = imr_rd;
      else if (poll_armed) bus_rdata = poll_word;
      else if (sel_isr)   bus_rdata = isr_rd;
      else                bus_rdata = irr_rd;
   end

   // R11: an acknowledge with nothing eligible reports the lowest-ranked input
   a_r11_spurious_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !int_req) |-> (int_vector[IDX_W-1:0] == SPUR_IDX));

   // R5: the request line needs an unmasked latched request
   a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> ((irr & ~imr) != '0));

   // R9: a valid poll read puts its input in service
   a_r9_poll_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_rd && int_req && !init_pulse) |=> isr[$past(pend_idx)]);

   // R7: nothing is requested while a same-or-higher input is in service
   a_r7_no_req_when_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (isr[0]) |-> !int_req);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, int_ack = 1'b0;
   logic [7:0] bus_wdata = '0, irq_lines = '0;
   logic [7:0] bus_rdata, int_vector;
   logic       int_req;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   prio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_lines(irq_lines), .int_req(int_req), .int_ack(int_ack),
      .int_vector(int_vector)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_a0 = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] q);
      @(negedge clk);
      bus_a0 = a; bus_rd = 1'b1;
      #1 q = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ack(output logic [7:0] v);
      @(negedge clk);
      int_ack = 1'b1;
      #1 v = int_vector;
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   task automatic lines(input logic [7:0] v);
      @(negedge clk);
      irq_lines = v;
      @(negedge clk);
   endtask

   task automatic init_seq(input logic [7:0] base);
      wr(1'b0, 8'h11);
      wr(1'b1, base);
      wr(1'b1, 8'h04);
      wr(1'b1, 8'h01);
   endtask

   initial begin
      #800000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] q, v, base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(1'b1, q);      check("R1 mask after reset", q, 8'hFF);
      check("R1 int_req after reset", {7'd0, int_req}, 8'h00);
      rd(1'b0, q);      check("R1 request readback after reset", q, 8'h00);

      // R2 init sequence keeps the mask, then the mask loads
      init_seq(8'h08);
      rd(1'b1, q);      check("R2 mask untouched by init words", q, 8'hFF);
      wr(1'b1, 8'h00);
      rd(1'b1, q);      check("R2 mask load after init", q, 8'h00);

      // R4 vector sweep over all inputs, two bases
      for (int b = 0; b < 2; b++) begin
         base = (b == 0) ? 8'h08 : 8'h40;
         if (b == 1) begin init_seq(base); wr(1'b1, 8'h00); end
         wr(1'b0, 8'h0B);
         for (int i = 0; i < 8; i++) begin
            lines(8'(1 << i));
            check("R4 int_req raised", {7'd0, int_req}, 8'h01);
            ack(v);
            check("R4 vector base plus input", v, base | 8'(i));
            lines(8'h00);
            rd(1'b0, q);  check("R4 in-service bit set", q, 8'(1 << i));
            wr(1'b0, 8'h20);
            rd(1'b0, q);  check("R8 in-service cleared by EOI", q, 8'h00);
         end
      end
      base = 8'h40;

      // R6 / R7 all ordered pairs
      for (int i = 0; i < 8; i++) begin
         for (int j = i + 1; j < 8; j++) begin
            lines(8'(1 << i) | 8'(1 << j));
            ack(v);
            check("R6 lower number wins", v, base | 8'(i));
            check("R7 lower rank blocked by in-service", {7'd0, int_req}, 8'h00);
            wr(1'b0, 8'h20);
            check("R7 request after EOI", {7'd0, int_req}, 8'h01);
            ack(v);
            check("R6 second input served", v, base | 8'(j));
            lines(8'h00);
            wr(1'b0, 8'h20);
         end
      end

      // R7 / R8 nesting
      lines(8'h20);
      ack(v);           check("R7 first served", v, base | 8'd5);
      lines(8'h24);
      check("R7 higher rank passes in-service", {7'd0, int_req}, 8'h01);
      ack(v);           check("R7 nested vector", v, base | 8'd2);
      rd(1'b0, q);      check("R8 two in service", q, 8'h24);
      wr(1'b0, 8'h20);
      rd(1'b0, q);      check("R8 lowest-numbered cleared only", q, 8'h20);
      rd(1'b0, q);      check("R10 selection persists", q, 8'h20);
      wr(1'b0, 8'h20);
      lines(8'h00);

      // R5 mask
      wr(1'b1, 8'hFB);
      lines(8'h10);
      check("R5 masked input quiet", {7'd0, int_req}, 8'h00);
      wr(1'b0, 8'h0A);
      rd(1'b0, q);      check("R5 masked edge latched", q, 8'h10);
      wr(1'b1, 8'h00);
      check("R5 unmask raises request", {7'd0, int_req}, 8'h01);
      ack(v);           check("R5 vector after unmask", v, base | 8'd4);
      lines(8'h00);
      wr(1'b0, 8'h20);

      // R9 poll
      lines(8'h40);
      wr(1'b0, 8'h0C);
      rd(1'b0, q);      check("R9 poll read", q, 8'h86);
      rd(1'b0, q);      check("R9 request cleared by poll", q, 8'h00);
      wr(1'b0, 8'h0B);
      rd(1'b0, q);      check("R9 poll sets in-service", q, 8'h40);
      lines(8'h00);
      wr(1'b0, 8'h20);
      wr(1'b0, 8'h0C);
      rd(1'b0, q);      check("R9 poll with nothing pending", q, 8'h07);

      // R11 spurious
      lines(8'h80);
      check("R11 request seen", {7'd0, int_req}, 8'h01);
      lines(8'h00);
      ack(v);           check("R11 spurious vector", v, base | 8'd7);
      rd(1'b0, q);      check("R11 in-service bit 7 clear", q, 8'h00);

      // R13 acknowledge and new edge in one cycle
      lines(8'h08);
      @(negedge clk);
      int_ack = 1'b1; irq_lines = 8'h0A;
      #1 v = int_vector;
      @(negedge clk);
      int_ack = 1'b0;
      check("R13 vector of earlier request", v, base | 8'd3);
      check("R13 new edge raises request", {7'd0, int_req}, 8'h01);
      ack(v);           check("R13 new edge served next", v, base | 8'd1);
      wr(1'b0, 8'h20);
      wr(1'b0, 8'h20);
      lines(8'h00);

      // R12 first init word clears in-service and requests
      lines(8'h02);
      ack(v);
      lines(8'h0A);
      wr(1'b1, 8'h30);
      init_seq(base);
      rd(1'b1, q);      check("R12 mask kept", q, 8'h30);
      rd(1'b0, q);      check("R12 request cleared, readback back to requests", q, 8'h00);
      wr(1'b0, 8'h0B);
      rd(1'b0, q);      check("R12 in-service cleared", q, 8'h00);
      check("R12 no request pending", {7'd0, int_req}, 8'h00);
      lines(8'h00);

      // R3 single-unit sequence skips cascade word
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h20);
      wr(1'b1, 8'h01);
      wr(1'b1, 8'h00);
      rd(1'b1, q);      check("R3 mask load after short sequence", q, 8'h00);
      lines(8'h01);
      ack(v);           check("R3 base from short sequence", v, 8'h20);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule